// File: doc/BRIEF.md
# Tag-Aware Frame Length Limit Checker

This block watches a packet stream that moves several octets per clock cycle. Each frame is marked with start-of-frame, end-of-frame and beat-valid qualifiers. The block adds up the octets of every frame, from the first destination-address octet through the last checksum octet. When the frame ends, it reports the measured length and says whether the frame is longer than allowed. The allowed length is a programmable maximum. That maximum grows by four octets when a frame carries one recognised 802.1Q tag and single-tag detection is enabled. It grows by eight octets when the frame carries two stacked tags and stacked-tag detection is enabled.

The block keeps no state except for the frame in flight, so one instance can sit on a transmit path and another on a receive path. Each instance is given its own maximum length. The result is a registered pulse, which is simple to feed into error handling or counting logic further down.

Top module: `ofc_oversize_check`

## Requirements
- R1: `res_len` equals the number of octets in the frame: every non-final beat counts DATA_BYTES octets, and the final beat counts DATA_BYTES minus `in_empty`.
- R2: A frame with no recognised tag is flagged oversize exactly when its length exceeds `max_len`, whatever the two detection enables are.
- R3: Octet k of a beat travels on `in_data[8k+7:8k]`, and a tag type field is big-endian (the earlier octet is the high byte). When octets 12–13 read 0x8100, no inner tag follows, and `vlan_en` is 1, the limit is `max_len`+4: a frame of exactly that length passes and one octet more fails.
- R4: A single-tagged frame gets no allowance when `vlan_en` is 0, even if `svlan_en` is 1.
- R5: When octets 12–13 read 0x88A8 or 0x8100, octets 16–17 read 0x8100, and `svlan_en` is 1, the limit is `max_len`+8.
- R6: When `svlan_en` is 0, a double-tagged frame whose outer type is 0x8100 gets the single-tag allowance if `vlan_en` is 1. With an outer type of 0x88A8 it gets no allowance.
- R7: `res_valid` is high for exactly one cycle, the cycle after the end-of-frame beat is accepted. `res_oversize` can only be high in that same cycle.
- R8: Reset clears `res_valid` and `res_oversize`, and it discards any frame that is partly counted.
- R9: Cycles with `in_valid` low inside a frame do not change the measured length or the tag detection.
- R10: A tag type field that is not fully inside the valid octets of the frame is not recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat qualifier |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | 8*DATA_BYTES | Beat octets, octet 0 in the low byte |
| in_empty | input | log2(DATA_BYTES) | Unused octets at the top of the last beat |
| max_len | input | LEN_W | Programmed maximum frame length |
| vlan_en | input | 1 | Enable the single-tag allowance |
| svlan_en | input | 1 | Enable the stacked-tag allowance |
| res_valid | output | 1 | Result strobe, one cycle after end of frame |
| res_oversize | output | 1 | Frame exceeded its limit |
| res_len | output | LEN_W | Measured frame length in octets |

## Verification
The assertions assume well-framed input. Every frame opens with a beat that has the start flag set, `in_empty` is zero except on the last beat, and `max_len` and both enables stay fixed while a frame is in flight. The properties compare `res_len` with the maximum as it was sampled on the end beat, so a limit that changes mid-frame would break them. The stimulus holds the limit and the enables from the first beat to the result and drives `in_empty` only together with `in_eop`. It places idle cycles only between beats of the same frame.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

   typedef enum logic [1:0] {
      TAG_NONE    = 2'd0,
      TAG_SINGLE  = 2'd1,
      TAG_STACKED = 2'd2
   } tag_kind_e;

   localparam logic [15:0] TPID_CUSTOMER = 16'h8100;
   localparam logic [15:0] TPID_SERVICE  = 16'h88A8;

   localparam int OUTER_TYPE_OCTET = 12;
   localparam int INNER_TYPE_OCTET = 16;

   localparam int ONE_TAG_OCTETS = 4;
   localparam int TWO_TAG_OCTETS = 8;

endpackage

// File: rtl/ofc_len_track.sv
module ofc_len_track #(
   parameter int DATA_BYTES = 8,
   parameter int LEN_W      = 16,
   parameter int IDX_W      = 3,
   parameter bit SATURATE   = 1'b1,
   localparam int EMPTY_W   = $clog2(DATA_BYTES),
   localparam int CNT_W     = $clog2(DATA_BYTES) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               beat_valid,
   input  logic               sop,
   input  logic               eop,
   input  logic [EMPTY_W-1:0] empty,
   output logic [IDX_W-1:0]   idx_now,
   output logic [CNT_W-1:0]   vbytes,
   output logic [LEN_W-1:0]   len_now
);

   logic [IDX_W-1:0] idx_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_base;
   logic [LEN_W:0]   len_sum;
   logic [IDX_W-1:0] idx_next;

   // A start beat begins a new frame whatever state was left behind.
   assign idx_now  = sop ? '0 : idx_q;
   assign len_base = sop ? '0 : len_q;
   assign vbytes   = eop ? (CNT_W'(DATA_BYTES) - CNT_W'(empty)) : CNT_W'(DATA_BYTES);
   assign len_sum  = {1'b0, len_base} + (LEN_W+1)'(vbytes);
   assign idx_next = (idx_now == '1) ? idx_now : idx_now + 1'b1;

   generate
      if (SATURATE) begin : g_sat
         assign len_now = len_sum[LEN_W] ? '1 : len_sum[LEN_W-1:0];
      end else begin : g_wrap
         assign len_now = len_sum[LEN_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         len_q <= '0;
      end else if (beat_valid) begin
         if (eop) begin
            idx_q <= '0;
            len_q <= '0;
         end else begin
            idx_q <= idx_next;
            len_q <= len_now;
         end
      end
   end

endmodule

// File: rtl/ofc_tag_detect.sv
module ofc_tag_detect
   import ofc_pkg::*;
#(
   parameter int DATA_BYTES = 8,
   parameter int IDX_W      = 3,
   localparam int CNT_W     = $clog2(DATA_BYTES) + 1,
   localparam int O_BEAT    = OUTER_TYPE_OCTET / DATA_BYTES,
   localparam int O_LANE    = OUTER_TYPE_OCTET % DATA_BYTES,
   localparam int I_BEAT    = INNER_TYPE_OCTET / DATA_BYTES,
   localparam int I_LANE    = INNER_TYPE_OCTET % DATA_BYTES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    beat_valid,
   input  logic                    sop,
   input  logic                    eop,
   input  logic [8*DATA_BYTES-1:0] data,
   input  logic [IDX_W-1:0]        idx_now,
   input  logic [CNT_W-1:0]        vbytes,
   output tag_kind_e               kind,
   output logic                    outer_is_cust
);

   logic [15:0] outer_field;
   logic [15:0] inner_field;
   logic        at_outer, at_inner;
   logic        hit_oc, hit_os, hit_ic;
   logic        st_oc, st_os, st_ic;
   logic        now_oc, now_os, now_ic;

   // Type fields are big-endian: the lower-numbered octet is the high byte.
   assign outer_field = {data[8*O_LANE +: 8], data[8*(O_LANE+1) +: 8]};
   assign inner_field = {data[8*I_LANE +: 8], data[8*(I_LANE+1) +: 8]};

   // Both octets of a field must lie among the valid octets of the beat.
   assign at_outer = beat_valid && (idx_now == IDX_W'(O_BEAT)) && (vbytes > CNT_W'(O_LANE + 1));
   assign at_inner = beat_valid && (idx_now == IDX_W'(I_BEAT)) && (vbytes > CNT_W'(I_LANE + 1));

   assign hit_oc = at_outer && (outer_field == TPID_CUSTOMER);
   assign hit_os = at_outer && (outer_field == TPID_SERVICE);
   assign hit_ic = at_inner && (inner_field == TPID_CUSTOMER);

   assign now_oc = (sop ? 1'b0 : st_oc) | hit_oc;
   assign now_os = (sop ? 1'b0 : st_os) | hit_os;
   assign now_ic = (sop ? 1'b0 : st_ic) | hit_ic;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_oc <= 1'b0;
         st_os <= 1'b0;
         st_ic <= 1'b0;
      end else if (beat_valid) begin
         st_oc <= eop ? 1'b0 : now_oc;
         st_os <= eop ? 1'b0 : now_os;
         st_ic <= eop ? 1'b0 : now_ic;
      end
   end

   always_comb begin
      if (now_ic && (now_oc || now_os)) kind = TAG_STACKED;
      else if (now_oc)                  kind = TAG_SINGLE;
      else                              kind = TAG_NONE;
   end

   assign outer_is_cust = now_oc;

endmodule

// File: rtl/ofc_limit_cmp.sv
module ofc_limit_cmp
   import ofc_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  tag_kind_e        kind,
   input  logic             outer_is_cust,
   input  logic             vlan_en,
   input  logic             svlan_en,
   input  logic [LEN_W-1:0] max_len,
   input  logic [LEN_W-1:0] len,
   output logic             over
);

   logic [3:0]     allow;
   logic [LEN_W:0] limit;

   always_comb begin
      allow = 4'd0;
      if (kind == TAG_STACKED && svlan_en)
         allow = 4'(TWO_TAG_OCTETS);
      else if (kind != TAG_NONE && outer_is_cust && vlan_en)
         allow = 4'(ONE_TAG_OCTETS);
   end

   // One extra bit so that the extended limit cannot wrap.
   assign limit = {1'b0, max_len} + (LEN_W+1)'(allow);
   assign over  = ({1'b0, len} > limit);

endmodule

// File: rtl/ofc_oversize_check.sv
module ofc_oversize_check
   import ofc_pkg::*;
#(
   parameter int DATA_BYTES = 8,
   parameter int LEN_W      = 16,
   parameter bit SATURATE   = 1'b1,
   localparam int EMPTY_W   = $clog2(DATA_BYTES),
   localparam int CNT_W     = $clog2(DATA_BYTES) + 1,
   localparam int IDX_W     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_sop,
   input  logic                    in_eop,
   input  logic [8*DATA_BYTES-1:0] in_data,
   input  logic [EMPTY_W-1:0]      in_empty,
   input  logic [LEN_W-1:0]        max_len,
   input  logic                    vlan_en,
   input  logic                    svlan_en,
   output logic                    res_valid,
   output logic                    res_oversize,
   output logic [LEN_W-1:0]        res_len
);

   generate
      if (DATA_BYTES < 4 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_width
         $error("DATA_BYTES must be a power of two, at least 4");
      end
      if (LEN_W < 8) begin : g_bad_len
         $error("LEN_W must be at least 8");
      end
      if ((INNER_TYPE_OCTET / DATA_BYTES) >= (1 << IDX_W) - 1) begin : g_bad_idx
         $error("beat index cannot reach the inner tag");
      end
   endgenerate

   logic [IDX_W-1:0] idx_now;
   logic [CNT_W-1:0] vbytes;
   logic [LEN_W-1:0] len_now;
   tag_kind_e        kind;
   logic             outer_is_cust;
   logic             over;

   ofc_len_track #(
      .DATA_BYTES (DATA_BYTES),
      .LEN_W      (LEN_W),
      .IDX_W      (IDX_W),
      .SATURATE   (SATURATE)
   ) u_len (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (in_valid),
      .sop        (in_sop),
      .eop        (in_eop),
      .empty      (in_empty),
      .idx_now    (idx_now),
      .vbytes     (vbytes),
      .len_now    (len_now)
   );

   ofc_tag_detect #(
      .DATA_BYTES (DATA_BYTES),
      .IDX_W      (IDX_W)
   ) u_tag (
      .clk           (clk),
      .rst_n         (rst_n),
      .beat_valid    (in_valid),
      .sop           (in_sop),
      .eop           (in_eop),
      .data          (in_data),
      .idx_now       (idx_now),
      .vbytes        (vbytes),
      .kind          (kind),
      .outer_is_cust (outer_is_cust)
   );

   ofc_limit_cmp #(
      .LEN_W (LEN_W)
   ) u_cmp (
      .kind          (kind),
      .outer_is_cust (outer_is_cust),
      .vlan_en       (vlan_en),
      .svlan_en      (svlan_en),
      .max_len       (max_len),
      .len           (len_now),
      .over          (over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_oversize <= 1'b0;
         res_len      <= '0;
      end else begin
         res_valid    <= in_valid && in_eop;
         res_oversize <= in_valid && in_eop && over;
         if (in_valid && in_eop) res_len <= len_now;
      end
   end

endmodule

// File: rtl/ofc_oversize_check_sva.sv
module ofc_oversize_check_sva #(
   parameter int DATA_BYTES = 8,
   parameter int LEN_W      = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_eop,
   input logic [LEN_W-1:0] max_len,
   input logic             vlan_en,
   input logic             svlan_en,
   input logic             res_valid,
   input logic             res_oversize,
   input logic [LEN_W-1:0] res_len
);

   AST_RESULT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid && in_eop)); // R7

   AST_FLAG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      res_oversize |-> res_valid); // R7

   AST_WITHIN_MAX_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_len <= $past(max_len))) |-> !res_oversize); // R2

   AST_BEYOND_TWO_TAGS_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && ({1'b0, res_len} > ({1'b0, $past(max_len)} + (LEN_W+1)'(8))))
         |-> res_oversize); // R5

   AST_NO_ENABLE_NO_ALLOWANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(vlan_en) && !$past(svlan_en))
         |-> (res_oversize == (res_len > $past(max_len)))); // R4

   AST_ONE_TAG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !$past(svlan_en)
         && ({1'b0, res_len} > ({1'b0, $past(max_len)} + (LEN_W+1)'(4))))
         |-> res_oversize); // R3

endmodule

bind ofc_oversize_check ofc_oversize_check_sva #(
   .DATA_BYTES (DATA_BYTES),
   .LEN_W      (LEN_W)
) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_eop       (in_eop),
   .max_len      (max_len),
   .vlan_en      (vlan_en),
   .svlan_en     (svlan_en),
   .res_valid    (res_valid),
   .res_oversize (res_oversize),
   .res_len      (res_len)
);

// File: tb/ofc_oversize_check_test.sv
module ofc_oversize_check_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic [63:0] in_data = '0;
   logic [2:0]  in_empty = '0;
   logic [15:0] max_len = 16'd64;
   logic        vlan_en = 1'b0;
   logic        svlan_en = 1'b0;
   logic        res_valid;
   logic        res_oversize;
   logic [15:0] res_len;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ofc_oversize_check uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_sop       (in_sop),
      .in_eop       (in_eop),
      .in_data      (in_data),
      .in_empty     (in_empty),
      .max_len      (max_len),
      .vlan_en      (vlan_en),
      .svlan_en     (svlan_en),
      .res_valid    (res_valid),
      .res_oversize (res_oversize),
      .res_len      (res_len)
   );

   // Columns: length, maximum, tag kind, vlan_en, svlan_en, idle gaps, expected oversize, spare.
   // Tag kind: 0 none, 1 one 0x8100, 2 0x88A8 over 0x8100, 3 0x8100 over 0x8100.
   localparam int NV = 19;
   localparam logic [39:0] TBL [0:NV-1] = '{
      {16'd64,   16'd64,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
      {16'd65,   16'd64,   2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00},
      {16'd68,   16'd64,   2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},
      {16'd69,   16'd64,   2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00},
      {16'd65,   16'd64,   2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00},
      {16'd64,   16'd64,   2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},
      {16'd65,   16'd64,   2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00},
      {16'd72,   16'd64,   2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00},
      {16'd73,   16'd64,   2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00},
      {16'd72,   16'd64,   2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00},
      {16'd65,   16'd64,   2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00},
      {16'd68,   16'd64,   2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},
      {16'd69,   16'd64,   2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00},
      {16'd65,   16'd64,   2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00},
      {16'd1522, 16'd1518, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},
      {16'd1519, 16'd1518, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00},
      {16'd13,   16'd10,   2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00},
      {16'd14,   16'd10,   2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},
      {16'd9,    16'd20,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00}
   };

   function automatic string req_of(int i);
      case (i)
         0, 1, 13, 15: return "R2";
         2, 3, 14, 17: return "R3";
         4, 5, 6:      return "R4";
         7, 8, 9:      return "R5";
         10, 11, 12:   return "R6";
         16:           return "R10";
         default:      return "R1";
      endcase
   endfunction

   function automatic logic [7:0] byte_of(int k, int kind);
      if (kind != 0 && k == 12) return (kind == 2) ? 8'h88 : 8'h81;
      if (kind != 0 && k == 13) return (kind == 2) ? 8'hA8 : 8'h00;
      if (kind >= 2 && k == 16) return 8'h81;
      if (kind >= 2 && k == 17) return 8'h00;
      return 8'((k * 7 + 3) & 8'h3F);
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(int n, int kind, bit gap);
      int beats;
      beats = (n + 7) / 8;
      for (int b = 0; b < beats; b++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (b == 0);
         in_eop   = (b == beats - 1);
         for (int l = 0; l < 8; l++) in_data[8*l +: 8] = byte_of(b * 8 + l, kind);
         in_empty = (b == beats - 1) ? 3'(beats * 8 - n) : 3'd0;
         if (gap && b != beats - 1) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      in_empty = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: outputs held low in reset.
      check("R8", "res_valid in reset", 32'(res_valid), 0);
      check("R8", "res_oversize in reset", 32'(res_oversize), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", "res_valid idle", 32'(res_valid), 0);

      for (int i = 0; i < NV; i++) begin
         max_len  = TBL[i][23:8];
         vlan_en  = TBL[i][5];
         svlan_en = TBL[i][4];
         send(int'(TBL[i][39:24]), int'(TBL[i][7:6]), TBL[i][3]);
         check("R7", "res_valid after end", 32'(res_valid), 1);
         check("R1", "res_len", 32'(res_len), 32'(TBL[i][39:24]));
         check(req_of(i), "res_oversize", 32'(res_oversize), 32'(TBL[i][2]));
         @(negedge clk);
         check("R7", "res_valid one cycle", 32'(res_valid), 0);
         check("R7", "res_oversize one cycle", 32'(res_oversize), 0);
      end

      // R7: two single-beat frames back to back give two adjacent results.
      max_len = 16'd4; vlan_en = 1'b0; svlan_en = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_empty = 3'd0;
      in_data = 64'h0706050403020100;
      @(negedge clk);
      check("R7", "first back-to-back oversize", 32'(res_oversize), 1);
      check("R1", "first back-to-back len", 32'(res_len), 8);
      in_empty = 3'd5;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_empty = 3'd0;
      check("R7", "second back-to-back valid", 32'(res_valid), 1);
      check("R7", "second back-to-back pass", 32'(res_oversize), 0);
      check("R1", "second back-to-back len", 32'(res_len), 3);
      @(negedge clk);
      check("R7", "strobe drops", 32'(res_valid), 0);

      // R8: reset mid-frame discards the partial count.
      max_len = 16'd64;
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0;
      @(negedge clk);
      in_sop = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R8", "res_valid after mid-frame reset", 32'(res_valid), 0);
      rst_n = 1'b1;
      send(20, 0, 1'b0);
      check("R8", "len after mid-frame reset", 32'(res_len), 20);
      check("R8", "pass after mid-frame reset", 32'(res_oversize), 0);

      // R9: many idle cycles inside a tagged frame.
      vlan_en = 1'b1;
      send(68, 1, 1'b1);
      check("R9", "len with gaps", 32'(res_len), 68);
      check("R9", "tag kept across gaps", 32'(res_oversize), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule